// File: doc/BRIEF.md
# I2C Transaction Sequencer Bridge

This block runs one complete short I2C transaction, started by a single register write, without software stepping through each byte. A transaction is a write phase, a read phase, or a write phase followed by a read phase. Each phase moves 1 to 8 bytes. Outgoing bytes are loaded beforehand into two 32-bit words. Incoming bytes are collected into two 32-bit words.

The bridge does not drive the bus pins. It issues byte-level commands to a separate I2C master engine: START, STOP, WRITE a byte, or READ a byte with ACK or NACK. The engine answers each command with one response pulse. That response carries the target's acknowledge for a written byte, or the byte that was read. When the transaction ends, on success or on error, the bridge sets a cause flag and can raise an interrupt.

Software reaches the bridge through a plain word-addressed register port. Writes take effect at the clock edge. Reads are combinational on the current address. The register word addresses are: 0 control, 1 TX low, 2 TX high, 3 RX low, 4 RX high, 5 status, 6 cause, 7 mask.

Top module: `i2c_tg_bridge`

## Requirements
- R1: After reset, the control, status, cause, mask, TX and RX registers all read 0, `irq` is low, and `cmd_valid` is low.
- R2: The control word has these fields: bit0 requests a write phase, bit1 a read phase, bits[11:2] hold the target address, bit12 selects 10-bit addressing, bits[15:13] hold the TX count minus one, bits[18:16] hold the RX count minus one, bit19 launches, and bit20 selects a repeated START. A control write launches only when the bridge is idle, bit19 is set and bit0 or bit1 is set. The first command, a START, appears one cycle after the write is taken. A launch word that requests no phase is ignored.
- R3: Each phase begins with its address bytes. In 7-bit mode the single byte is {addr[6:0], dir}. In 10-bit mode the first byte is {5'b11110, addr[9:8], dir} and the second is addr[7:0]. dir is 0 for the write phase and 1 for the read phase.
- R4: The write phase sends TX-count bytes from the TX words. Byte i is bits [8i+7:8i] of {TX high, TX low}.
- R5: The read phase issues RX-count READ commands. Only the last one asks for a NACK. Received byte i is stored in bits [8i+7:8i] of {RX high, RX low}. The RX words clear at each launch.
- R6: When both phases are requested, the read phase follows the write phase. If bit20 is 1, a single START separates them. If bit20 is 0, a STOP and then a START separate them.
- R7: Every transaction ends with a STOP. When the STOP is answered, bit19 of the control register clears, cause bit0 sets, and `irq` equals cause bit0 AND mask bit0. Writing 0 to the cause register clears it.
- R8: A missing acknowledge on any address byte or TX byte ends the transaction at once with a STOP and sets status bit0. A launch clears status bit0.
- R9: While a transaction is busy, a nonzero control write and writes to the TX words have no effect.
- R10: Writing 0 to the control register returns the bridge to idle at once. No further command is issued, and no completion is flagged.
- R11: `cmd_valid` lasts one cycle. No new command is issued until the engine has responded to the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| irq | output | 1 | Completion interrupt (cause AND mask) |
| cmd_valid | output | 1 | One-cycle command pulse to the master engine |
| cmd_op | output | 2 | Command: 0 START, 1 STOP, 2 WRITE, 3 READ |
| cmd_byte | output | 8 | Byte to send with WRITE |
| cmd_nack | output | 1 | READ answers with NACK instead of ACK |
| rsp_valid | input | 1 | Engine finished the outstanding command |
| rsp_ack | input | 1 | Target acknowledged the written byte |
| rsp_data | input | 8 | Byte received for READ |

## Verification
The assertions assume the master engine answers each command with exactly one `rsp_valid` pulse. They also assume that pulse never arrives in the same cycle as the command, and never arrives while no command is outstanding. They further assume software does not write 0 to the cause register in the same cycle a transaction completes. The bench's engine model meets all of these: it keeps one outstanding command, answers after 0 to 2 idle cycles, and drops its pending answer when a transaction is aborted. The bench clears the cause flag only after each transaction has fully ended.

// File: rtl/i2c_tg_pkg.sv
package i2c_tg_pkg;

    localparam int TG_MAXB = 8;
    localparam int TG_DW   = 32;
    localparam int TG_RAW  = 3;

    typedef enum logic [1:0] {
        CMD_START = 2'd0,
        CMD_STOP  = 2'd1,
        CMD_WRITE = 2'd2,
        CMD_READ  = 2'd3
    } cmd_op_e;

    // Field positions are decoded by software: keep order and widths.
    typedef struct packed {
        logic       rstart;   // bit20
        logic       go;       // bit19
        logic [2:0] rx_m1;    // bits18:16
        logic [2:0] tx_m1;    // bits15:13
        logic       ten;      // bit12
        logic [9:0] taddr;    // bits11:2
        logic       rd;       // bit1
        logic       wr;       // bit0
    } ctrl_t;

    typedef enum logic [2:0] {
        SQ_IDLE, SQ_START, SQ_AHI, SQ_ALO, SQ_WBYTE, SQ_RBYTE, SQ_MIDSTOP, SQ_STOP
    } seq_e;

    localparam logic [2:0] RA_CTRL  = 3'd0;
    localparam logic [2:0] RA_TXLO  = 3'd1;
    localparam logic [2:0] RA_RXLO  = 3'd3;
    localparam logic [2:0] RA_STAT  = 3'd5;
    localparam logic [2:0] RA_CAUSE = 3'd6;
    localparam logic [2:0] RA_MASK  = 3'd7;

    function automatic logic [7:0] addr_first(ctrl_t c, logic dir);
        return c.ten ? {5'b11110, c.taddr[9:8], dir} : {c.taddr[6:0], dir};
    endfunction

    function automatic logic launch_word_ok(logic [TG_DW-1:0] w);
        return w[19] && (w[0] || w[1]);
    endfunction

endpackage

// File: rtl/i2c_tg_regs.sv
module i2c_tg_regs
    import i2c_tg_pkg::*;
#(
    parameter int DW  = TG_DW,
    parameter int RAW = TG_RAW,
    parameter int NB  = TG_MAXB,
    localparam int IW  = $clog2(NB),
    localparam int TXW = NB * 8,
    localparam int NW  = TXW / DW
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           reg_we,
    input  logic [RAW-1:0] reg_addr,
    input  logic [DW-1:0]  reg_wdata,
    output logic [DW-1:0]  reg_rdata,
    input  logic           seq_done,
    input  logic           seq_err,
    input  logic           rx_we,
    input  logic [IW-1:0]  rx_idx,
    input  logic [7:0]     rx_byte,
    output ctrl_t          ctrl,
    output logic [TXW-1:0] tx_data,
    output logic           launch,
    output logic           abort,
    output logic           irq
);

    ctrl_t          ctrl_q;
    logic [TXW-1:0] tx_q;
    logic [TXW-1:0] rx_q;
    logic           err_q;
    logic           cause_q;
    logic           mask_q;
    logic           busy;
    logic           wr_ctrl;

    assign busy    = ctrl_q.go;
    assign wr_ctrl = reg_we && (reg_addr == RAW'(RA_CTRL));
    assign launch  = wr_ctrl && !busy && launch_word_ok(reg_wdata);
    assign abort   = wr_ctrl && (reg_wdata == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            tx_q    <= '0;
            rx_q    <= '0;
            err_q   <= 1'b0;
            cause_q <= 1'b0;
            mask_q  <= 1'b0;
        end else begin
            if (abort)
                ctrl_q <= '0;
            else if (launch)
                ctrl_q <= ctrl_t'(reg_wdata[$bits(ctrl_t)-1:0]);
            else if (seq_done)
                ctrl_q.go <= 1'b0;

            if (reg_we && !busy) begin
                for (int w = 0; w < NW; w++) begin
                    if (reg_addr == RAW'(int'(RA_TXLO) + w))
                        tx_q[w*DW +: DW] <= reg_wdata;
                end
            end

            if (launch)
                rx_q <= '0;
            else if (rx_we)
                rx_q[{rx_idx, 3'b000} +: 8] <= rx_byte;

            if (launch || abort)
                err_q <= 1'b0;
            else if (seq_done && seq_err)
                err_q <= 1'b1;

            if (seq_done)
                cause_q <= 1'b1;
            else if (reg_we && reg_addr == RAW'(RA_CAUSE) && reg_wdata == '0)
                cause_q <= 1'b0;

            if (reg_we && reg_addr == RAW'(RA_MASK))
                mask_q <= reg_wdata[0];
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            RAW'(RA_CTRL):  reg_rdata = DW'(ctrl_q);
            RAW'(RA_STAT):  reg_rdata = DW'(err_q);
            RAW'(RA_CAUSE): reg_rdata = DW'(cause_q);
            RAW'(RA_MASK):  reg_rdata = DW'(mask_q);
            default: ;
        endcase
        for (int w = 0; w < NW; w++) begin
            if (reg_addr == RAW'(int'(RA_TXLO) + w)) reg_rdata = tx_q[w*DW +: DW];
            if (reg_addr == RAW'(int'(RA_RXLO) + w)) reg_rdata = rx_q[w*DW +: DW];
        end
    end

    assign ctrl    = ctrl_q;
    assign tx_data = tx_q;
    assign irq     = cause_q & mask_q;

    AST_TX_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.go && $past(ctrl_q.go)) |-> $stable(tx_q)); // R9
    AST_GO_DROPS: assert property (@(posedge clk) disable iff (rst)
        seq_done |=> !ctrl_q.go); // R7
    AST_ERR_LATCHED: assert property (@(posedge clk) disable iff (rst)
        (seq_done && seq_err) |=> err_q); // R8

endmodule

// File: rtl/i2c_tg_seq.sv
module i2c_tg_seq
    import i2c_tg_pkg::*;
#(
    parameter int NB = TG_MAXB,
    localparam int IW  = $clog2(NB),
    localparam int TXW = NB * 8
) (
    input  logic           clk,
    input  logic           rst,
    input  ctrl_t          ctrl,
    input  logic [TXW-1:0] tx_data,
    input  logic           launch,
    input  logic           abort,
    input  logic           rsp_valid,
    input  logic           rsp_ack,
    input  logic [7:0]     rsp_data,
    output logic           cmd_valid,
    output cmd_op_e        cmd_op,
    output logic [7:0]     cmd_byte,
    output logic           cmd_nack,
    output logic           rx_we,
    output logic [IW-1:0]  rx_idx,
    output logic [7:0]     rx_byte,
    output logic           done,
    output logic           err,
    output logic           idle
);

    seq_e          st, st_n;
    logic          issued, issued_n;
    logic          rd_ph, rd_n;
    logic [IW-1:0] cnt, cnt_n;
    logic          err_q, err_n;
    logic          rd_now;
    logic          take;
    seq_e          data_st;

    assign rd_now  = rd_ph | ~ctrl.wr;
    assign take    = rsp_valid && issued && (st != SQ_IDLE);
    assign data_st = rd_now ? SQ_RBYTE : SQ_WBYTE;

    assign cmd_valid = (st != SQ_IDLE) && !issued;

    always_comb begin
        cmd_op   = CMD_START;
        cmd_byte = 8'h00;
        cmd_nack = 1'b0;
        case (st)
            SQ_AHI: begin
                cmd_op   = CMD_WRITE;
                cmd_byte = addr_first(ctrl, rd_now);
            end
            SQ_ALO: begin
                cmd_op   = CMD_WRITE;
                cmd_byte = ctrl.taddr[7:0];
            end
            SQ_WBYTE: begin
                cmd_op   = CMD_WRITE;
                cmd_byte = tx_data[{cnt, 3'b000} +: 8];
            end
            SQ_RBYTE: begin
                cmd_op   = CMD_READ;
                cmd_nack = (cnt == ctrl.rx_m1);
            end
            SQ_MIDSTOP, SQ_STOP: cmd_op = CMD_STOP;
            default: ;
        endcase
    end

    always_comb begin
        st_n     = st;
        issued_n = issued;
        rd_n     = rd_ph;
        cnt_n    = cnt;
        err_n    = err_q;
        if (cmd_valid)
            issued_n = 1'b1;
        if (take) begin
            issued_n = 1'b0;
            case (st)
                SQ_START: st_n = SQ_AHI;
                SQ_AHI: begin
                    if (!rsp_ack) begin
                        st_n  = SQ_STOP;
                        err_n = 1'b1;
                    end else if (ctrl.ten) begin
                        st_n = SQ_ALO;
                    end else begin
                        st_n  = data_st;
                        cnt_n = '0;
                    end
                end
                SQ_ALO: begin
                    if (!rsp_ack) begin
                        st_n  = SQ_STOP;
                        err_n = 1'b1;
                    end else begin
                        st_n  = data_st;
                        cnt_n = '0;
                    end
                end
                SQ_WBYTE: begin
                    if (!rsp_ack) begin
                        st_n  = SQ_STOP;
                        err_n = 1'b1;
                    end else if (cnt == ctrl.tx_m1) begin
                        if (ctrl.rd) begin
                            rd_n = 1'b1;
                            st_n = ctrl.rstart ? SQ_START : SQ_MIDSTOP;
                        end else begin
                            st_n = SQ_STOP;
                        end
                    end else begin
                        cnt_n = cnt + 1'b1;
                    end
                end
                SQ_RBYTE: begin
                    if (cnt == ctrl.rx_m1) st_n = SQ_STOP;
                    else                   cnt_n = cnt + 1'b1;
                end
                SQ_MIDSTOP: st_n = SQ_START;
                default:    st_n = SQ_IDLE;
            endcase
        end
        if (launch) begin
            st_n     = SQ_START;
            issued_n = 1'b0;
            rd_n     = 1'b0;
            cnt_n    = '0;
            err_n    = 1'b0;
        end
        if (abort) begin
            st_n     = SQ_IDLE;
            issued_n = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= SQ_IDLE;
            issued <= 1'b0;
            rd_ph  <= 1'b0;
            cnt    <= '0;
            err_q  <= 1'b0;
        end else begin
            st     <= st_n;
            issued <= issued_n;
            rd_ph  <= rd_n;
            cnt    <= cnt_n;
            err_q  <= err_n;
        end
    end

    assign done    = take && (st == SQ_STOP);
    assign err     = err_q;
    assign rx_we   = take && (st == SQ_RBYTE);
    assign rx_idx  = cnt;
    assign rx_byte = rsp_data;
    assign idle    = (st == SQ_IDLE);

    AST_CMD_PULSE: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |=> !cmd_valid); // R11
    AST_NACK_STOPS: assert property (@(posedge clk) disable iff (rst)
        (take && !rsp_ack && !abort && (st == SQ_AHI || st == SQ_ALO || st == SQ_WBYTE))
        |=> (st == SQ_STOP)); // R8
    AST_ACTIVE_BUSY: assert property (@(posedge clk) disable iff (rst)
        (st != SQ_IDLE) |-> ctrl.go); // R7

endmodule

// File: rtl/i2c_tg_bridge.sv
module i2c_tg_bridge
    import i2c_tg_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_we,
    input  logic [2:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        irq,
    output logic        cmd_valid,
    output logic [1:0]  cmd_op,
    output logic [7:0]  cmd_byte,
    output logic        cmd_nack,
    input  logic        rsp_valid,
    input  logic        rsp_ack,
    input  logic [7:0]  rsp_data
);

    localparam int NB  = TG_MAXB;
    localparam int IW  = $clog2(NB);
    localparam int TXW = NB * 8;

    ctrl_t          ctrl;
    logic [TXW-1:0] tx_data;
    logic           launch;
    logic           abort;
    logic           seq_done;
    logic           seq_err;
    logic           seq_idle;
    logic           rx_we;
    logic [IW-1:0]  rx_idx;
    logic [7:0]     rx_byte;
    cmd_op_e        op_e;

    i2c_tg_regs #(.DW(TG_DW), .RAW(TG_RAW), .NB(NB)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .seq_done  (seq_done),
        .seq_err   (seq_err),
        .rx_we     (rx_we),
        .rx_idx    (rx_idx),
        .rx_byte   (rx_byte),
        .ctrl      (ctrl),
        .tx_data   (tx_data),
        .launch    (launch),
        .abort     (abort),
        .irq       (irq)
    );

    i2c_tg_seq #(.NB(NB)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .ctrl      (ctrl),
        .tx_data   (tx_data),
        .launch    (launch),
        .abort     (abort),
        .rsp_valid (rsp_valid),
        .rsp_ack   (rsp_ack),
        .rsp_data  (rsp_data),
        .cmd_valid (cmd_valid),
        .cmd_op    (op_e),
        .cmd_byte  (cmd_byte),
        .cmd_nack  (cmd_nack),
        .rx_we     (rx_we),
        .rx_idx    (rx_idx),
        .rx_byte   (rx_byte),
        .done      (seq_done),
        .err       (seq_err),
        .idle      (seq_idle)
    );

    assign cmd_op = op_e;

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !ctrl.go |-> !cmd_valid); // R10
    AST_LAUNCH_START: assert property (@(posedge clk) disable iff (rst)
        launch |=> (cmd_valid && cmd_op == 2'd0)); // R2
    AST_GO_TRACKS_SEQ: assert property (@(posedge clk) disable iff (rst)
        ctrl.go == !seq_idle); // R7

endmodule

// File: tb/i2c_tg_bridge_bench.sv
module i2c_tg_bridge_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic        irq;
    logic        cmd_valid;
    logic [1:0]  cmd_op;
    logic [7:0]  cmd_byte;
    logic        cmd_nack;
    logic        rsp_valid = 1'b0;
    logic        rsp_ack = 1'b0;
    logic [7:0]  rsp_data = 8'd0;

    always #4 clk = ~clk;

    i2c_tg_bridge u_i2c_tg_bridge (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_byte(cmd_byte),
        .cmd_nack(cmd_nack), .rsp_valid(rsp_valid), .rsp_ack(rsp_ack),
        .rsp_data(rsp_data)
    );

    int n_chk = 0;
    int n_bad = 0;
    int expq[$];
    logic [63:0] exp_rx;
    bit   exp_err;
    bit   pend = 0;
    int   pcnt = 0;
    int   lat_sel = 0;
    logic [1:0] last_op = 2'd0;
    int   wr_seen = 0;
    int   rd_seen = 0;
    int   nack_at = -1;
    logic [7:0] rx_pat [8];
    bit   mcause = 0;
    bit   mmask = 0;
    int   k_w;
    bit   dead;

    task automatic chk(string what, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    // Engine model and per-clock comparison.
    always @(negedge clk) begin
        if (!rst) begin
            chk("R7 irq level", irq, mcause & mmask);
            rsp_valid = 1'b0;
            if (cmd_valid) begin
                chk("R11 command while outstanding", pend, 0);
                if (expq.size() == 0) begin
                    chk("R10 unexpected command", 1, 0);
                end else begin
                    int e;
                    e = expq.pop_front();
                    chk("R3/R4/R5/R6 command stream", {cmd_op, cmd_nack, cmd_byte}, 64'(e[10:0]));
                end
                pend = 1;
                pcnt = lat_sel;
                lat_sel = (lat_sel + 1) % 3;
                last_op = cmd_op;
            end else if (pend) begin
                if (pcnt == 0) begin
                    rsp_valid = 1'b1;
                    rsp_ack = 1'b1;
                    rsp_data = 8'h00;
                    if (last_op == 2'd2) begin
                        rsp_ack = (wr_seen != nack_at);
                        wr_seen++;
                    end
                    if (last_op == 2'd3) begin
                        rsp_data = rx_pat[rd_seen];
                        rd_seen++;
                    end
                    if (last_op == 2'd1 && expq.size() == 0) mcause = 1;
                    pend = 0;
                end else begin
                    pcnt--;
                end
            end
        end
    end

    task automatic wreg(logic [2:0] a, logic [31:0] d);
        @(posedge clk); #1;
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_we = 1'b0;
        if (a == 3'd6 && d == 0) mcause = 0;
        if (a == 3'd7) mmask = d[0];
    endtask

    task automatic rreg(logic [2:0] a, output logic [31:0] d);
        @(posedge clk); #1;
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    function automatic logic [7:0] abyte(logic [9:0] a, bit ten, bit dir);
        return ten ? {5'b11110, a[9:8], dir} : {a[6:0], dir};
    endfunction

    task automatic pushw(logic [7:0] b);
        if (!dead) begin
            expq.push_back((2 << 9) | int'(b));
            if (k_w == nack_at) dead = 1;
            k_w++;
        end
    endtask

    task automatic addr_phase(logic [9:0] a, bit ten, bit dir);
        pushw(abyte(a, ten, dir));
        if (ten) pushw(a[7:0]);
    endtask

    task automatic build(bit wr, bit rd, bit ten, bit rs, logic [9:0] a,
                         int txn, int rxn, logic [63:0] tx);
        expq.delete();
        k_w = 0; dead = 0; exp_rx = '0;
        expq.push_back(0 << 9);
        if (wr) begin
            addr_phase(a, ten, 0);
            for (int i = 0; i < txn; i++) pushw(tx[8*i +: 8]);
        end
        if (wr && rd && !dead) begin
            if (!rs) expq.push_back(1 << 9);
            expq.push_back(0 << 9);
        end
        if (rd && !dead) begin
            addr_phase(a, ten, 1);
            if (!dead) begin
                for (int i = 0; i < rxn; i++) begin
                    expq.push_back((3 << 9) | ((i == rxn - 1) ? 256 : 0));
                    exp_rx[8*i +: 8] = rx_pat[i];
                end
            end
        end
        expq.push_back(1 << 9);
        exp_err = dead;
    endtask

    function automatic logic [31:0] cword(bit wr, bit rd, bit ten, bit rs,
                                          logic [9:0] a, int txn, int rxn);
        logic [2:0] tm, rm;
        tm = (txn > 0) ? 3'(txn - 1) : 3'd0;
        rm = (rxn > 0) ? 3'(rxn - 1) : 3'd0;
        return (32'(rs) << 20) | (32'd1 << 19) | (32'(rm) << 16) | (32'(tm) << 13) |
               (32'(ten) << 12) | (32'(a) << 2) | (32'(rd) << 1) | 32'(wr);
    endfunction

    task automatic launch_run(bit wr, bit rd, bit ten, bit rs, logic [9:0] a,
                              int txn, int rxn, logic [63:0] tx, int nk, int seed);
        for (int i = 0; i < 8; i++) rx_pat[i] = 8'(8'h3C + 17 * i + seed);
        nack_at = nk; wr_seen = 0; rd_seen = 0;
        wreg(3'd1, tx[31:0]);
        wreg(3'd2, tx[63:32]);
        build(wr, rd, ten, rs, a, txn, rxn, tx);
        wreg(3'd0, cword(wr, rd, ten, rs, a, txn, rxn));
    endtask

    task automatic finish_run(string tag);
        logic [31:0] d;
        while (expq.size() != 0 || pend) @(posedge clk);
        repeat (3) @(posedge clk);
        rreg(3'd0, d); chk({tag, " R7 launch bit cleared"}, d[19], 0);
        rreg(3'd6, d); chk({tag, " R7 cause set"}, d, 1);
        rreg(3'd5, d); chk({tag, " R8 status error"}, d, 32'(exp_err));
        rreg(3'd3, d); chk({tag, " R5 RX low"}, d, exp_rx[31:0]);
        rreg(3'd4, d); chk({tag, " R5 RX high"}, d, exp_rx[63:32]);
        wreg(3'd6, 32'd0);
        rreg(3'd6, d); chk({tag, " R7 cause cleared"}, d, 0);
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        // R1: reset state
        for (int a = 0; a < 8; a++) begin
            rreg(3'(a), d);
            chk("R1 register reset value", d, 0);
        end
        chk("R1 irq low", irq, 0);
        chk("R1 cmd_valid low", cmd_valid, 0);

        wreg(3'd7, 32'd1);
        // R2 R3 R4: 7-bit write, 3 bytes
        launch_run(1, 0, 0, 0, 10'h052, 3, 0, 64'h8877665544332211, -1, 0);
        finish_run("T1");
        // R5: 8-byte read
        launch_run(0, 1, 0, 0, 10'h02C, 0, 8, 64'h0, -1, 5);
        finish_run("T2");
        // R6 R3: 10-bit combined with repeated START
        launch_run(1, 1, 1, 1, 10'h2A5, 2, 5, 64'h00000000_0000BEEF, -1, 9);
        finish_run("T3");
        // R6: combined with STOP between phases
        launch_run(1, 1, 0, 0, 10'h011, 1, 1, 64'h5A, -1, 2);
        finish_run("T4");
        // R8: address not acknowledged
        launch_run(1, 1, 0, 1, 10'h033, 4, 4, 64'h44332211, 0, 1);
        finish_run("T5");
        // R8: second TX byte not acknowledged
        launch_run(1, 0, 0, 0, 10'h070, 4, 0, 64'hA4A3A2A1, 2, 1);
        finish_run("T6");
        // R8: error cleared by next launch; 10-bit read only
        launch_run(0, 1, 1, 0, 10'h155, 0, 2, 64'h0, -1, 7);
        finish_run("T7");

        // R9: writes during busy are ignored
        launch_run(1, 0, 0, 0, 10'h021, 6, 0, 64'h0000CAFEF00DD00D, -1, 0);
        wreg(3'd0, cword(0, 1, 0, 0, 10'h3FF, 0, 8));
        wreg(3'd1, 32'hFFFFFFFF);
        finish_run("T8");
        rreg(3'd1, d); chk("R9 TX low kept", d, 32'hF00DD00D);

        // R10: abort mid-transaction
        launch_run(1, 0, 0, 0, 10'h066, 8, 0, 64'h0102030405060708, -1, 0);
        while (expq.size() > 6) @(posedge clk);
        wreg(3'd0, 32'd0);
        expq.delete(); pend = 0;
        repeat (20) @(posedge clk);
        rreg(3'd0, d); chk("R10 control idle after abort", d, 0);
        rreg(3'd6, d); chk("R10 no completion after abort", d, 0);

        // R2: launch word without a phase is ignored
        wreg(3'd0, 32'h00080000);
        repeat (10) @(posedge clk);
        rreg(3'd0, d); chk("R2 phaseless launch ignored", d, 0);

        repeat (5) @(posedge clk);
        summary();
        $finish;
    end

endmodule